// File: doc/BRIEF.md
# Watch Interval Timer with Tone Output

This block counts ticks of a 32.768 kHz watch clock, presented as a one-cycle enable on the system clock. A binary divider chain supplies two things. It raises a periodic interrupt request at one of four intervals, and it drives a square-wave tone output at one of four audio frequencies. The interrupt request is a single-cycle pulse, and it is meant to set a pending bit elsewhere in the chip.

Software writes a run bit, an interval select, a tone select and an interrupt-enable bit. When the run bit is cleared, the divider chain is reset to zero. The first interval after the timer is started again is therefore a full interval. The interval select can be changed while the timer runs without disturbing the divider. The next request then follows the next rollover of the newly chosen tap.

Top module: `watch_timer`

## Requirements
- R1: After reset, `irq_pulse` and `buzz_out` are low and the divider holds zero, so the first request after the run bit is set comes a full interval later.
- R2: With `run_en` high and one tick per cycle, the first request after `run_en` rises comes exactly 2^k ticks later. k is 15, 14, 13 or 7 for `ivl_sel` = 0, 1, 2 or 3 (1 s, 0.5 s, 0.25 s and 3.91 ms at 32.768 kHz).
- R3: While the timer runs, successive requests are spaced exactly 2^k ticks apart, with k as in R2.
- R4: `irq_pulse` is high for exactly one clock cycle per request.
- R5: With `irq_en` low, no request is raised, but the divider keeps counting. Setting `irq_en` later gives a request at the next rollover measured from the start of the run.
- R6: Clearing `run_en` resets the divider. After `run_en` is set again, the first request comes a full 2^k ticks later.
- R7: `buzz_out` is a 50% duty square wave. Its high and low phases each last 2^(6-s) ticks for `tone_sel` = s, which gives fw/128, fw/64, fw/32 and fw/16 (256, 512, 1024 and 2048 Hz). It first rises 2^(6-s) ticks after the run starts.
- R8: While `run_en` is low, `buzz_out` and `irq_pulse` are low.
- R9: The divider advances only on cycles where `wclk_tick` is high. With ticks held off, no request is raised and the tone does not change.
- R10: Changing `ivl_sel` while running does not clear the divider. The next request comes at the next rollover of the newly selected tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_tick | input | 1 | One-cycle enable per watch-clock period |
| run_en | input | 1 | Run bit; low stops the timer and clears the divider |
| ivl_sel | input | 2 | Interval select (0: 2^15, 1: 2^14, 2: 2^13, 3: 2^7 ticks) |
| tone_sel | input | 2 | Tone select (0: fw/128 up to 3: fw/16) |
| irq_en | input | 1 | Interrupt enable |
| irq_pulse | output | 1 | One-cycle interrupt request to the pending register |
| buzz_out | output | 1 | Tone square wave |

## Verification
The bench sweeps all four interval selects. For each one it measures the tick count from the start of the run to the first request, and for the short taps also the spacing to the second request. A wrong tap or an off-by-one in the rollover detection shows up as a count that is off by a power of two or by one. It sweeps all four tone selects and times the first rise, the high phase and the low phase. This separates a wrong bit choice from a wrong duty cycle.

Further runs cover the following situations:
- a stop in the middle of a period, which shows whether the divider is really cleared;
- an interval switch in the middle of a period, which shows whether it is not cleared;
- a masked run followed by unmasking, which shows that counting continues while the request is suppressed;
- ticks held off, which shows that only ticks advance the chain.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        IVL_LONG    = 2'd0,
        IVL_HALF    = 2'd1,
        IVL_QUARTER = 2'd2,
        IVL_SHORT   = 2'd3
    } ivl_sel_e;

    typedef struct packed {
        logic run;
        logic tick;
        logic ie;
    } wt_ctl_t;

    typedef struct packed {
        logic [3:0] hit;
        logic [3:0] tone;
    } wt_taps_t;

    localparam int unsigned NUM_SEL = 4;

    function automatic int unsigned tone_bit(input int unsigned slow_exp,
                                             input int unsigned sel);
        return slow_exp - 1 - sel;
    endfunction

endpackage

// File: rtl/wt_divider.sv
module wt_divider #(
    parameter int unsigned CNT_W = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  wt_pkg::wt_ctl_t     ctl,
    output logic [CNT_W-1:0]    cnt
);
    always_ff @(posedge clk) begin
        if (rst || !ctl.run) begin
            cnt <= '0;
        end else if (ctl.tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wt_tap_decode.sv
module wt_tap_decode #(
    parameter int unsigned CNT_W      = 15,
    parameter int unsigned IVL_E0     = 15,
    parameter int unsigned IVL_E1     = 14,
    parameter int unsigned IVL_E2     = 13,
    parameter int unsigned IVL_E3     = 7,
    parameter int unsigned TONE_SLOW  = 7
) (
    input  logic [CNT_W-1:0]  cnt,
    output wt_pkg::wt_taps_t  taps
);
    localparam int unsigned EXPS [4] = '{IVL_E0, IVL_E1, IVL_E2, IVL_E3};

    for (genvar i = 0; i < wt_pkg::NUM_SEL; i++) begin : g_tap
        localparam int unsigned E  = EXPS[i];
        localparam int unsigned TB = wt_pkg::tone_bit(TONE_SLOW, i);
        // all bits below the tap set: the next tick rolls the tap over
        assign taps.hit[i]  = &cnt[E-1:0];
        assign taps.tone[i] = cnt[TB];
    end
endmodule

// File: rtl/wt_irq_gen.sv
module wt_irq_gen (
    input  logic              clk,
    input  logic              rst,
    input  wt_pkg::wt_ctl_t   ctl,
    input  wt_pkg::ivl_sel_e  sel,
    input  logic [3:0]        hit,
    output logic              irq
);
    logic fire;

    always_comb begin
        fire = ctl.run && ctl.tick && ctl.ie && hit[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= fire;
        end
    end
endmodule

// File: rtl/watch_timer.sv
module watch_timer #(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned IVL_E0    = 15,
    parameter int unsigned IVL_E1    = 14,
    parameter int unsigned IVL_E2    = 13,
    parameter int unsigned IVL_E3    = 7,
    parameter int unsigned TONE_SLOW = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wclk_tick,
    input  logic       run_en,
    input  logic [1:0] ivl_sel,
    input  logic [1:0] tone_sel,
    input  logic       irq_en,
    output logic       irq_pulse,
    output logic       buzz_out
);
    import wt_pkg::*;

    wt_ctl_t           ctl;
    wt_taps_t          taps;
    logic [CNT_W-1:0]  cnt;
    ivl_sel_e          isel;

    always_comb begin
        ctl.run  = run_en;
        ctl.tick = wclk_tick;
        ctl.ie   = irq_en;
        isel     = ivl_sel_e'(ivl_sel);
    end

    wt_divider #(.CNT_W(CNT_W)) u_div (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .cnt (cnt)
    );

    wt_tap_decode #(
        .CNT_W     (CNT_W),
        .IVL_E0    (IVL_E0),
        .IVL_E1    (IVL_E1),
        .IVL_E2    (IVL_E2),
        .IVL_E3    (IVL_E3),
        .TONE_SLOW (TONE_SLOW)
    ) u_dec (
        .cnt  (cnt),
        .taps (taps)
    );

    wt_irq_gen u_irq (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .sel (isel),
        .hit (taps.hit),
        .irq (irq_pulse)
    );

    assign buzz_out = run_en & taps.tone[tone_sel];
endmodule

// File: rtl/wt_checker.sv
module wt_checker (
    input logic       clk,
    input logic       rst,
    input logic       wclk_tick,
    input logic       run_en,
    input logic [1:0] tone_sel,
    input logic       irq_en,
    input logic       irq_pulse,
    input logic       buzz_out
);
    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    assert_masked_R5: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> !irq_pulse);

    assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !irq_pulse);

    assert_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(wclk_tick));

    assert_tone_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (run_en && $past(run_en) && !$past(wclk_tick) && $stable(tone_sel))
            |-> $stable(buzz_out));
endmodule

bind watch_timer wt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wclk_tick (wclk_tick),
    .run_en    (run_en),
    .tone_sel  (tone_sel),
    .irq_en    (irq_en),
    .irq_pulse (irq_pulse),
    .buzz_out  (buzz_out)
);

// File: tb/sim_watch_timer.sv
`timescale 1ns/1ps
module sim_watch_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wclk_tick = 1'b1;
    logic       run_en = 1'b0;
    logic [1:0] ivl_sel = 2'd0;
    logic [1:0] tone_sel = 2'd0;
    logic       irq_en = 1'b0;
    logic       irq_pulse;
    logic       buzz_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    watch_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .wclk_tick (wclk_tick),
        .run_en    (run_en),
        .ivl_sel   (ivl_sel),
        .tone_sel  (tone_sel),
        .irq_en    (irq_en),
        .irq_pulse (irq_pulse),
        .buzz_out  (buzz_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int ivl_ticks(input int s);
        case (s)
            0: return 1 << 15;
            1: return 1 << 14;
            2: return 1 << 13;
            default: return 1 << 7;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one edge, sample 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // edges until irq_pulse is seen high (limit returns limit+1)
    task automatic wait_irq(input int limit, output int n);
        n = 0;
        do begin
            step();
            n = n + 1;
        end while (!irq_pulse && n <= limit);
    endtask

    task automatic wait_buzz(input logic v, input int limit, output int n);
        n = 0;
        do begin
            step();
            n = n + 1;
        end while (buzz_out !== v && n <= limit);
    endtask

    task automatic stop_run();
        @(negedge clk);
        run_en = 1'b0;
        step();
        step();
    endtask

    initial begin
        int n;
        int cnt_irq;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 irq after reset", irq_pulse, 0);
        check("R1 buzz after reset", buzz_out, 0);
        @(negedge clk);
        rst = 1'b0;
        step();
        // R8: idle with ticks running
        check("R8 irq while stopped", irq_pulse, 0);
        check("R8 buzz while stopped", buzz_out, 0);

        // R2 / R3 / R4: sweep interval selects
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            ivl_sel = s[1:0];
            irq_en  = 1'b1;
            run_en  = 1'b1;
            wait_irq(40000, n);
            check($sformatf("R2 first interval sel=%0d", s), n, ivl_ticks(s));
            step();
            check("R4 pulse width", irq_pulse, 0);
            if (s >= 2) begin
                wait_irq(40000, n);
                check($sformatf("R3 spacing sel=%0d", s), n + 1, ivl_ticks(s));
            end
            stop_run();
            check("R8 irq after stop", irq_pulse, 0);
        end

        // R7: sweep tone selects
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            tone_sel = s[1:0];
            run_en = 1'b1;
            wait_buzz(1'b1, 200, n);
            check($sformatf("R7 first rise sel=%0d", s), n, 1 << (6 - s));
            wait_buzz(1'b0, 200, n);
            check($sformatf("R7 high phase sel=%0d", s), n, 1 << (6 - s));
            wait_buzz(1'b1, 200, n);
            check($sformatf("R7 low phase sel=%0d", s), n, 1 << (6 - s));
            stop_run();
            check("R8 buzz after stop", buzz_out, 0);
        end

        // R6: stop mid-period, restart, full interval
        @(negedge clk);
        ivl_sel = 2'd3;
        run_en = 1'b1;
        repeat (50) step();
        stop_run();
        @(negedge clk);
        run_en = 1'b1;
        wait_irq(1000, n);
        check("R6 interval after restart", n, 128);
        stop_run();

        // R10: switch from long tap to short tap after 100 ticks
        @(negedge clk);
        ivl_sel = 2'd0;
        run_en = 1'b1;
        repeat (100) step();
        @(negedge clk);
        ivl_sel = 2'd3;
        wait_irq(1000, n);
        check("R10 request after switch", n + 100, 128);
        stop_run();

        // R5: masked run, then unmask
        @(negedge clk);
        irq_en = 1'b0;
        run_en = 1'b1;
        cnt_irq = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (irq_pulse) cnt_irq = cnt_irq + 1;
        end
        check("R5 requests while masked", cnt_irq, 0);
        @(negedge clk);
        irq_en = 1'b1;
        wait_irq(1000, n);
        check("R5 request after unmask", n + 200, 256);
        stop_run();

        // R9: ticks held off
        @(negedge clk);
        wclk_tick = 1'b0;
        tone_sel = 2'd3;
        run_en = 1'b1;
        cnt_irq = 0;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            if (irq_pulse) cnt_irq = cnt_irq + 1;
            if (buzz_out) n = n + 1;
        end
        check("R9 requests without ticks", cnt_irq, 0);
        check("R9 tone without ticks", n, 0);
        @(negedge clk);
        wclk_tick = 1'b1;
        wait_irq(1000, n);
        check("R9 request once ticks resume", n, 128);
        stop_run();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule